// File: doc/BRIEF.md
# Multi-Channel Phase-Shifted Square-Wave Driver

This block produces the logic-level drive pattern for a bank of electrostatic micromirrors driven by bipolar pulse-width modulation. A free-running period counter generates one reference square wave at 50% duty for the shared mirror node. Every channel emits the same square wave, delayed by a programmable phase, together with its exact logical complement for the opposing electrode. The tilt of a mirror is set by that phase delay alone. A zero delay gives no difference between the channel and reference waves. A half-period delay gives the widest difference pulse. The average difference is always zero.

A system controller writes one 12-bit tilt coefficient per channel through a plain addressed write port. The coefficients are double-buffered. A new value waits in a shadow register and becomes active only at the start of the next period, so a channel never shows a truncated or doubled pulse. One period is 4096 system clock ticks, so the clock-to-PWM ratio sets the phase resolution. The channel count is a parameter. High-voltage level shifting sits outside this block.

Top module: `mirror_phase_driver`

## Requirements
- R1: `common_out` is high exactly while the period counter is below 2048. The counter runs over 0..4095, so the wave has a 4096-cycle period and 50% duty. It is high in the first cycle after reset.
- R2: `ch_true[i]` is high exactly while (counter − active coefficient of channel i) modulo 4096 is below 2048.
- R3: An active coefficient of 0 makes `ch_true[i]` equal to `common_out` in every cycle. An active coefficient of 2048 makes it the inverse of `common_out` in every cycle.
- R4: `ch_comp[i]` is the logical inverse of `ch_true[i]` in every cycle.
- R5: A write with `wr_en` high and `wr_addr` below NUM_CH stores `wr_data` in that channel's shadow register. All shadow values become active on the clock edge at which the counter passes from 4095 to 0. A write sampled on that same edge becomes active one period later.
- R6: A write with `wr_addr` at or above NUM_CH changes no coefficient, shadow or active.
- R7: A synchronous reset (`rst` high at a clock edge) clears the counter and every shadow and active coefficient to 0.
- R8: Outside reset, the counter advances by exactly one each clock and wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | ADDR_W | Channel index of the write |
| wr_data | input | 12 | Phase coefficient in clock ticks |
| common_out | output | 1 | Reference square wave for the shared mirror node |
| ch_true | output | NUM_CH | Phase-delayed square wave per channel |
| ch_comp | output | NUM_CH | Complement of ch_true per channel |

## Verification
The assertions assume that `rst` is held high for at least two clock edges at start-up. They also assume that `wr_en`, `wr_addr` and `wr_data` change only away from the rising clock edge. The bench drives every input on the falling edge and holds reset for several cycles, so both assumptions hold. Out-of-range writes use addresses whose low bits alias a live channel. A write to a dropped address therefore shows up on a real output if it is not ignored.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  parameter int unsigned PH_W = 12;
  typedef logic [PH_W-1:0] phase_t;
  localparam phase_t PH_LAST = '1;

  // Lag of the counter behind a coefficient, modulo the period.
  function automatic phase_t phase_lag(input phase_t cnt, input phase_t coef);
    return cnt - coef;
  endfunction

  // A wave is high in the first half of its own period.
  function automatic logic wave_level(input phase_t ph);
    return ~ph[PH_W-1];
  endfunction
endpackage

// File: rtl/mpd_period_counter.sv
module mpd_period_counter
  import mpd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t cnt,
  output logic   wrap
);
  phase_t cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign wrap = (cnt_q == PH_LAST);
endmodule

// File: rtl/mpd_coef_bank.sv
module mpd_coef_bank
  import mpd_pkg::*;
#(
  parameter int unsigned NUM_CH = 240,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned FLAT_W = NUM_CH * PH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  phase_t            wr_data,
  input  logic              wrap,
  output logic [FLAT_W-1:0] shadow_flat,
  output logic [FLAT_W-1:0] active_flat
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    phase_t shadow_q, active_q;
    logic   hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (hit)  shadow_q <= wr_data;
        if (wrap) active_q <= shadow_q;
      end
    end

    assign shadow_flat[i*PH_W +: PH_W] = shadow_q;
    assign active_flat[i*PH_W +: PH_W] = active_q;
  end
endmodule

// File: rtl/mpd_phase_gen.sv
module mpd_phase_gen
  import mpd_pkg::*;
#(
  parameter int unsigned NUM_CH = 240,
  localparam int unsigned FLAT_W = NUM_CH * PH_W
) (
  input  phase_t            cnt,
  input  logic [FLAT_W-1:0] active_flat,
  output logic              common_out,
  output logic [NUM_CH-1:0] ch_true,
  output logic [NUM_CH-1:0] ch_comp
);
  assign common_out = wave_level(cnt);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wave
    logic lvl;
    assign lvl        = wave_level(phase_lag(cnt, active_flat[i*PH_W +: PH_W]));
    assign ch_true[i] = lvl;
    assign ch_comp[i] = ~lvl;
  end
endmodule

// File: rtl/mirror_phase_driver.sv
module mirror_phase_driver
  import mpd_pkg::*;
#(
  parameter int unsigned NUM_CH = 240,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PH_W-1:0]   wr_data,
  output logic              common_out,
  output logic [NUM_CH-1:0] ch_true,
  output logic [NUM_CH-1:0] ch_comp
);
  localparam int unsigned FLAT_W = NUM_CH * PH_W;

  // Named internal events, visible to the bound checker.
  phase_t            cnt;
  logic              wrap;
  logic [FLAT_W-1:0] shadow_flat;
  logic [FLAT_W-1:0] active_flat;

  mpd_period_counter u_cnt (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt),
    .wrap (wrap)
  );

  mpd_coef_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wrap        (wrap),
    .shadow_flat (shadow_flat),
    .active_flat (active_flat)
  );

  mpd_phase_gen #(.NUM_CH(NUM_CH)) u_gen (
    .cnt         (cnt),
    .active_flat (active_flat),
    .common_out  (common_out),
    .ch_true     (ch_true),
    .ch_comp     (ch_comp)
  );
endmodule

// File: rtl/mpd_checker.sv
module mpd_checker
  import mpd_pkg::*;
#(
  parameter int unsigned NUM_CH = 240,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned FLAT_W = NUM_CH * PH_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              common_out,
  input logic [NUM_CH-1:0] ch_true,
  input phase_t            cnt,
  input logic              wrap,
  input logic [FLAT_W-1:0] shadow_flat,
  input logic [FLAT_W-1:0] active_flat
);
  bit armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  logic oob;
  assign oob = wr_en && ({1'b0, wr_addr} >= (ADDR_W+1)'(NUM_CH));

  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == phase_t'($past(cnt) + 1'b1));

  p_common_rise_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(common_out)) |-> cnt == '0);

  p_zero_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (active_flat == '0) |-> (ch_true == {NUM_CH{common_out}}));

  p_active_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrap)) |-> $stable(active_flat));

  p_ignore_wr_r6: assert property (@(posedge clk) disable iff (rst)
    oob |=> $stable(shadow_flat));

  p_reset_clear_r7: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> (cnt == '0 && active_flat == '0 && shadow_flat == '0));
endmodule

bind mirror_phase_driver mpd_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .common_out  (common_out),
  .ch_true     (ch_true),
  .cnt         (cnt),
  .wrap        (wrap),
  .shadow_flat (shadow_flat),
  .active_flat (active_flat)
);

// File: tb/mirror_phase_driver_bench.sv
`timescale 1ns/1ps
module mirror_phase_driver_bench;
  localparam int NCH = 4;
  localparam int AW  = 3;
  localparam int PER = 4096;
  localparam int HALF = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic common_out;
  logic [NCH-1:0] ch_true, ch_comp;

  mirror_phase_driver #(.NUM_CH(NCH), .ADDR_W(AW)) u_mirror_phase_driver (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .common_out(common_out), .ch_true(ch_true), .ch_comp(ch_comp)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int mcnt = 0;
  int msh[NCH];
  int mact[NCH];

  initial begin
    for (int i = 0; i < NCH; i++) begin msh[i] = 0; mact[i] = 0; end
  end

  always @(posedge clk) begin
    if (rst) begin
      mcnt = 0;
      for (int i = 0; i < NCH; i++) begin msh[i] = 0; mact[i] = 0; end
    end else begin
      if (mcnt == PER-1)
        for (int i = 0; i < NCH; i++) mact[i] = msh[i];
      if (wr_en && int'(wr_addr) < NCH) msh[int'(wr_addr)] = int'(wr_data);
      mcnt = (mcnt + 1) % PER;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cnt=%0d)", req, act, exp, mcnt);
    end
  endtask

  function automatic int ref_lvl(input int c, input int coef);
    return (((c - coef + PER) % PER) < HALF) ? 1 : 0;
  endfunction

  // Per-cycle comparison against the reference model
  bit live = 1'b0;
  always @(negedge clk) begin
    if (live && !rst) begin
      check(int'(common_out) == ((mcnt < HALF) ? 1 : 0), "R1 common", int'(common_out), (mcnt < HALF) ? 1 : 0);
      for (int i = 0; i < NCH; i++) begin
        check(int'(ch_true[i]) == ref_lvl(mcnt, mact[i]), "R2 ch_true", int'(ch_true[i]), ref_lvl(mcnt, mact[i]));
        check(ch_comp[i] == ~ch_true[i], "R4 ch_comp", int'(ch_comp[i]), int'(~ch_true[i]));
      end
    end
  end

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (mcnt != v);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 12'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    check(common_out == 1'b1, "R7 reset common", int'(common_out), 1);
    check(ch_true == '1, "R7 reset ch_true", int'(ch_true), 15);
    check(ch_comp == '0, "R7 reset ch_comp", int'(ch_comp), 0);
    rst = 1'b0;
    live = 1'b1;

    wait_cnt(10);
    wr(0, 1); wr(1, 4095); wr(2, 2048); wr(3, 2047);
    wait_cnt(3000);
    check(ch_true[2] == common_out, "R5 shadow not yet active", int'(ch_true[2]), int'(common_out));
    wait_cnt(0);
    check(ch_true[0] == 1'b0, "R2 wrap coef 1 at cnt 0", int'(ch_true[0]), 0);
    check(ch_true[1] == 1'b1, "R2 coef 4095 at cnt 0", int'(ch_true[1]), 1);
    wait_cnt(1);
    check(ch_true[0] == 1'b1, "R2 coef 1 at cnt 1", int'(ch_true[0]), 1);
    wait_cnt(5);
    check(ch_true[2] == ~common_out, "R3 coef 2048 inverse", int'(ch_true[2]), int'(~common_out));
    wait_cnt(2047);
    check(ch_true[1] == 1'b0, "R2 coef 4095 at cnt 2047", int'(ch_true[1]), 0);

    // R6 out-of-range writes alias channels 1 and 2 in the low bits
    wait_cnt(200);
    wr(5, 2048); wr(6, 0); wr(7, 100);
    wait_cnt(100);
    check(ch_true[1] == 1'b1, "R6 ignored addr 5", int'(ch_true[1]), 1);
    check(ch_true[2] == 1'b0, "R6 ignored addr 6", int'(ch_true[2]), 0);

    // R5 write sampled on the wrap edge lands one period later
    wait_cnt(4095);
    wr(3, 0);
    wait_cnt(10);
    check(ch_true[3] == 1'b0, "R5 wrap-edge write deferred", int'(ch_true[3]), 0);
    wait_cnt(4095);
    wait_cnt(10);
    check(ch_true[3] == 1'b1, "R5 deferred write active", int'(ch_true[3]), 1);

    // R7 mid-run reset
    wait_cnt(1500);
    wr(0, 3000);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(ch_true == '1 && common_out, "R7 mid-run reset outputs", int'(ch_true), 15);
    wait_cnt(4095);
    wait_cnt(20);
    check(ch_true == {NCH{common_out}}, "R7 coefficients cleared", int'(ch_true), 15);
    check(ch_comp == ~ch_true, "R4 after reset", int'(ch_comp), 0);
    repeat (50) @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule